// File: doc/BRIEF.md
# Paired-Register GPIO Expander Core

This block is the register bank and pin logic of a 16-pin I/O expander sitting behind a serial bus. The bus slave ahead of it has already turned bit traffic into byte events:
- a write-start strobe;
- a data-byte strobe carrying one byte;
- a read-request strobe that consumes the byte on `rd_data`;
- a stop strobe.

Eight byte-wide registers form four pairs. Registers 0/1 return input levels, 2/3 hold output values, 4/5 hold polarity inversion and 6/7 hold direction.

A write transaction opens with a command byte that loads the register pointer. After every later data byte the pointer flips to the other register of its pair, so a long burst ping-pongs between the two halves. Reads after the transaction has closed start at the pointer and flip it in the same way.

Each pin has separate value and enable outputs. The pin inputs pass through a synchronizer before they are read, and the input read is XORed with the polarity bits.

Top module: `gpio_pair_expander`

## Requirements
- R1: After reset `pin_out` is all ones and `pin_oe` is all zeros. Registers 2, 3, 6 and 7 read 0xFF, and registers 4 and 5 read 0x00.
- R2: The first `byte_vld` byte after `wr_start` is a command. It sets the pointer to its low three bits, so 0x0E selects register 6.
- R3: Within a write transaction, each `byte_vld` byte after the command is stored at the pointer. The pointer then flips its bit 0 (3 to 2 to 3, and so on) for any number of bytes.
- R4: Data bytes aimed at registers 0 or 1 change no register and no pin output, but they still flip the pointer.
- R5: Reading register 0 or 1 returns the synchronized pin level XORed with polarity register 4 or 5, whatever the direction. Register 0 covers pins 7:0 and register 1 covers pins 15:8. A pin change is visible on `rd_data` after SYNC_STAGES rising edges.
- R6: Reading register 2 or 3 returns the stored value, not the pin level.
- R7: `pin_oe` bit n is the inverse of direction bit n, so 1 means input. Register 6 holds pins 7:0 and register 7 holds pins 15:8. `pin_out` carries output registers 2 (pins 7:0) and 3 (pins 15:8).
- R8: With no write transaction open, `rd_data` shows the register at the pointer, and each `rd_req` flips pointer bit 0.
- R9: After `stop`, a `byte_vld` byte with no new `wr_start` is ignored. `rd_req` during an open write transaction does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a write transaction |
| byte_vld | input | 1 | Strobe for a received byte |
| byte_data | input | PORT_W | Received byte |
| rd_req | input | 1 | Consumes `rd_data` and advances the pointer |
| stop | input | 1 | Closes the transaction |
| rd_data | output | PORT_W | Register at the pointer |
| pin_in | input | 2*PORT_W | Raw pin levels |
| pin_out | output | 2*PORT_W | Pin drive values |
| pin_oe | output | 2*PORT_W | Pin driver enables |

## Verification
The bench builds the block with PORT_W=8 and SYNC_STAGES=2. With a two-stage synchronizer, the exact edge at which a pin change reaches the input read path can be pinned down and checked on both sides of that edge. A table of burst writes covers every writable pair, including a command above 7. Directed cases then cover input-register writes, stray bytes after stop and polarity-inverted input reads.

// File: rtl/gpio_pair_expander.sv
module gpio_pair_expander #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_start,
  input  logic                  byte_vld,
  input  logic [PORT_W-1:0]     byte_data,
  input  logic                  rd_req,
  input  logic                  stop,
  output logic [PORT_W-1:0]     rd_data,
  input  logic [2*PORT_W-1:0]   pin_in,
  output logic [2*PORT_W-1:0]   pin_out,
  output logic [2*PORT_W-1:0]   pin_oe
);
  localparam int PIN_W = 2 * PORT_W;

  logic [2:0]                  ptr;
  logic                        in_wr, cmd_pend;
  logic [1:0][PORT_W-1:0]      out_q, pol_q, cfg_q;
  logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_q;
  logic [1:0][PORT_W-1:0]      pin_s;

  wire cmd_fire = byte_vld && in_wr && cmd_pend;
  wire dat_fire = byte_vld && in_wr && !cmd_pend;
  wire rd_fire  = rd_req && !in_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      in_wr    <= 1'b0;
      cmd_pend <= 1'b0;
    end else if (wr_start) begin
      in_wr    <= 1'b1;
      cmd_pend <= 1'b1;
    end else if (stop) begin
      in_wr    <= 1'b0;
      cmd_pend <= 1'b0;
    end else if (cmd_fire) begin
      ptr      <= byte_data[2:0];
      cmd_pend <= 1'b0;
    end else if (dat_fire || rd_fire) begin
      ptr[0]   <= ~ptr[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (dat_fire && !wr_start && !stop) begin
      case (ptr[2:1])
        2'd1:    out_q[ptr[0]] <= byte_data;
        2'd2:    pol_q[ptr[0]] <= byte_data;
        2'd3:    cfg_q[ptr[0]] <= byte_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (ptr[2:1])
      2'd0:    rd_data = pin_s[ptr[0]] ^ pol_q[ptr[0]];
      2'd1:    rd_data = out_q[ptr[0]];
      2'd2:    rd_data = pol_q[ptr[0]];
      default: rd_data = cfg_q[ptr[0]];
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;
endmodule

// File: rtl/gpio_pair_expander_chk.sv
module gpio_pair_expander_chk #(
  parameter int PORT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_start,
  input logic                stop,
  input logic                byte_vld,
  input logic [PORT_W-1:0]   byte_data,
  input logic                rd_req,
  input logic [2*PORT_W-1:0] pin_out,
  input logic [2*PORT_W-1:0] pin_oe,
  input logic [2:0]          ptr,
  input logic                in_wr,
  input logic                cmd_pend
);
  wire quiet = !wr_start && !stop;

  AST_CMD_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && in_wr && cmd_pend |=> ptr == $past(byte_data[2:0])); // R2

  AST_DATA_FLIPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && in_wr && !cmd_pend |=> ptr == ($past(ptr) ^ 3'd1)); // R3

  AST_INPUT_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && in_wr && !cmd_pend && ptr[2:1] == 2'd0 |=> $stable(pin_out) && $stable(pin_oe)); // R4

  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && in_wr && !cmd_pend && ptr == 3'd2 |=> pin_out[PORT_W-1:0] == $past(byte_data)); // R7

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && in_wr && !cmd_pend && ptr == 3'd6 |=> pin_oe[PORT_W-1:0] == ~$past(byte_data)); // R7

  AST_RD_FLIPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && rd_req && !in_wr |=> ptr == ($past(ptr) ^ 3'd1)); // R8

  AST_STRAY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && byte_vld && !in_wr && !rd_req |=> $stable(ptr) && $stable(pin_out) && $stable(pin_oe)); // R9
endmodule

bind gpio_pair_expander gpio_pair_expander_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .stop(stop),
  .byte_vld(byte_vld), .byte_data(byte_data), .rd_req(rd_req),
  .pin_out(pin_out), .pin_oe(pin_oe), .ptr(ptr), .in_wr(in_wr), .cmd_pend(cmd_pend)
);

// File: tb/gpio_pair_expander_tb.sv
module gpio_pair_expander_tb;
  logic clk = 0, rst_n = 0;
  logic wr_start = 0, byte_vld = 0, rd_req = 0, stop = 0;
  logic [7:0] byte_data = 0;
  logic [15:0] pin_in = 0;
  logic [7:0] rd_data;
  logic [15:0] pin_out, pin_oe;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_pair_expander #(.PORT_W(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .rd_req(rd_req), .stop(stop), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  // command, first data byte, second data byte
  localparam logic [23:0] VEC [6] = '{
    24'h03A53C, 24'h021122, 24'h040FF0, 24'h058001, 24'h0E00FF, 24'h0755AA };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) wr_start = 1; @(negedge clk) wr_start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop = 1; @(negedge clk) stop = 0;
  endtask
  task automatic send(input logic [7:0] d);
    @(negedge clk) begin byte_vld = 1; byte_data = d; end
    @(negedge clk) byte_vld = 0;
  endtask
  task automatic point(input logic [7:0] c);
    pulse_start(); send(c); pulse_stop();
  endtask
  task automatic rd(input string req, input logic [7:0] exp);
    @(negedge clk) rd_req = 1;
    #1 chk(req, {8'h0, rd_data}, {8'h0, exp});
    @(negedge clk) rd_req = 0;
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", pin_out, 16'hFFFF);
    chk("R1", pin_oe, 16'h0000);
    point(8'h02); rd("R1", 8'hFF); rd("R1", 8'hFF);
    point(8'h04); rd("R1", 8'h00); rd("R1", 8'h00);
    point(8'h06); rd("R1", 8'hFF); rd("R1", 8'hFF);

    foreach (VEC[i]) begin
      pulse_start();
      send(VEC[i][23:16]); send(VEC[i][15:8]); send(VEC[i][7:0]);
      pulse_stop();
      point(VEC[i][23:16]);
      rd("R3", VEC[i][15:8]);
      rd("R8", VEC[i][7:0]);
    end
    #1;
    chk("R7", pin_oe, 16'hAA55);
    chk("R7", pin_out, 16'h2211);
    point(8'h0E); rd("R2", 8'hAA);

    pin_in = 16'h1234;
    repeat (3) @(negedge clk);
    point(8'h00); rd("R5", 8'h35); rd("R5", 8'h92);

    point(8'h00);
    @(negedge clk) pin_in = 16'h00FF;
    @(negedge clk) #1 chk("R5", {8'h0, rd_data}, 16'h0035);
    @(negedge clk) #1 chk("R5", {8'h0, rd_data}, 16'h00FE);

    point(8'h02); rd("R6", 8'h11); rd("R6", 8'h22);

    pulse_start(); send(8'h00); send(8'h5A); pulse_stop();
    #1;
    chk("R4", pin_out, 16'h2211);
    chk("R4", pin_oe, 16'hAA55);
    rd("R4", 8'h00 ^ 8'h80);

    point(8'h02);
    send(8'h77);
    #1 chk("R9", pin_out, 16'h2211);
    rd("R9", 8'h11);

    pulse_start(); send(8'h06);
    @(negedge clk) rd_req = 1; @(negedge clk) rd_req = 0;
    pulse_stop();
    rd("R9", 8'hAA);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule